// File: doc/BRIEF.md
# Interleaved burst channel reassembler

This block watches a receive stream that delivers up to four words per clock, grouped into bursts, where bursts belonging to different channels may alternate freely. From that stream it tracks each channel's current packet: whether one is in progress and how many bytes it has gathered so far. When a packet ends, it emits a single-cycle completion record with the channel, the total byte length and a flag for any protocol fault seen during that packet. A separate one-cycle error pulse marks every input cycle that broke the stream rules.

The channel number is only meaningful on a burst's opening cycle. The block captures it there and applies it to every later cycle of the same burst, whatever the channel input shows meanwhile. Payload bytes are not stored. Only the framing strobes and counts are consumed, so no data bus enters the block. Words are 8 bytes wide and valid words sit in the top positions of the bus. Sixteen channels are tracked.

Top module: `burst_reasm`

## Requirements
- R1: A cycle with `in_nvalid` = 0 is idle and is ignored whatever the other inputs show. It causes no completion and no error pulse, and it changes no burst or packet state.
- R2: A non-idle cycle with `in_sob` set starts a burst on channel `in_chan`. If `in_eob` is also set, the burst is that one cycle long.
- R3: The channel captured at burst start applies to every cycle up to and including the one with `in_eob`, even if `in_chan` changes in the meantime.
- R4: A cycle's byte count is `in_nvalid`×8 when `in_eop[3]` is 0. When `in_eop[3]` is 1 it is (`in_nvalid`−1)×8 plus `in_eop[2:0]`, where a value of 0 in `in_eop[2:0]` stands for 8.
- R5: A packet may span several bursts, with other channels' bursts in between. Its length is the sum of the byte counts of all its cycles.
- R6: One cycle after a cycle with `in_eop[3]` = 1, `done_vld` is high for exactly one cycle. `done_chan`, `done_len` and `done_err` describe the packet, and that channel is then closed.
- R7: `in_sop` together with `in_sob` on a channel whose packet is already open is an error. The length restarts from that cycle, and the resulting completion has `done_err` = 1.
- R8: A non-start cycle on a channel with no open packet is an error. It opens a packet that counts those bytes, and the resulting completion has `done_err` = 1.
- R9: `in_nvalid` above 4 is an error, and the cycle is counted as four words.
- R10: A non-idle cycle outside a burst without `in_sob` is an error and is otherwise dropped. No channel state changes.
- R11: `err_pulse` is high in the cycle after any cycle that meets the error conditions of R7–R10, and low after all other cycles.
- R12: A synchronous active-high `rst` closes all channels, clears the in-burst state and clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_sop | input | 1 | Packet start, meaningful with `in_sob` |
| in_sob | input | 1 | Burst start |
| in_eob | input | 1 | Burst end |
| in_nvalid | input | 3 | Number of valid words; 0 means idle |
| in_eop | input | 4 | Bit 3: packet end; bits 2:0: valid bytes in the last word (0 = 8) |
| in_chan | input | 4 | Channel, sampled on burst start only |
| done_vld | output | 1 | Completion strobe |
| done_chan | output | 4 | Channel of the completed packet |
| done_len | output | 16 | Byte length of the completed packet |
| done_err | output | 1 | Completed packet saw a protocol fault |
| err_pulse | output | 1 | Previous input cycle broke a stream rule |

## Verification
On every cycle the assertions check that idle input never produces a completion or an error, that an over-range word count and an unframed data cycle always raise the error pulse, and that a single-cycle packet completes on the channel shown at its start. The length arithmetic, the accumulation across interleaved bursts and the holding of the captured channel while the channel input changes can only be shown by the bench's scenarios. The same applies to the recovery after faults and the clearing done by reset. The bench sweeps every channel, word count and tail byte value for single-cycle packets.

// File: rtl/burst_reasm.sv
module burst_reasm #(
  parameter int NUM_CH     = 16,
  parameter int WORDS      = 4,
  parameter int WORD_BYTES = 8,
  parameter int LEN_W      = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int NV_W  = $clog2(WORDS + 1),
  localparam int TB_W  = $clog2(WORD_BYTES),
  localparam int EOP_W = TB_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_sop,
  input  logic             in_sob,
  input  logic             in_eob,
  input  logic [NV_W-1:0]  in_nvalid,
  input  logic [EOP_W-1:0] in_eop,
  input  logic [CH_W-1:0]  in_chan,
  output logic             done_vld,
  output logic [CH_W-1:0]  done_chan,
  output logic [LEN_W-1:0] done_len,
  output logic             done_err,
  output logic             err_pulse
);

  logic              in_burst_q;
  logic [CH_W-1:0]   burst_ch_q;
  logic [NUM_CH-1:0] open_q;
  logic [NUM_CH-1:0] perr_q;
  logic [LEN_W-1:0]  cnt_q [NUM_CH];

  logic              active, framed, take, sop, is_eop, nv_bad, ch_open;
  logic              e_dup, e_orph, e_nv, e_frame, cyc_err, sticky;
  logic [CH_W-1:0]   cyc_ch;
  logic [NV_W-1:0]   nv_eff;
  logic [TB_W-1:0]   tail;
  logic [LEN_W-1:0]  nv_l, tail_l, cyc_bytes, base, total;

  assign active  = in_nvalid != '0;
  assign framed  = in_sob | in_burst_q;
  assign take    = active & framed;
  assign cyc_ch  = in_sob ? in_chan : burst_ch_q;
  assign sop     = in_sop & in_sob;
  assign is_eop  = in_eop[EOP_W-1];
  assign tail    = in_eop[TB_W-1:0];
  assign nv_bad  = in_nvalid > NV_W'(WORDS);
  assign nv_eff  = nv_bad ? NV_W'(WORDS) : in_nvalid;
  assign ch_open = open_q[cyc_ch];

  assign nv_l      = LEN_W'(nv_eff);
  assign tail_l    = (tail == '0) ? LEN_W'(WORD_BYTES) : LEN_W'(tail);
  assign cyc_bytes = is_eop ? (nv_l - 1'b1) * LEN_W'(WORD_BYTES) + tail_l
                            : nv_l * LEN_W'(WORD_BYTES);

  assign e_dup   = take & sop & ch_open;
  assign e_orph  = take & ~sop & ~ch_open;
  assign e_nv    = active & nv_bad;
  assign e_frame = active & ~framed;
  assign cyc_err = e_dup | e_orph | e_nv | e_frame;

  assign base   = (ch_open & ~sop) ? cnt_q[cyc_ch] : '0;
  assign total  = base + cyc_bytes;
  assign sticky = (ch_open & ~sop & perr_q[cyc_ch]) | e_dup | e_orph | e_nv;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_burst_q <= 1'b0;
      burst_ch_q <= '0;
      open_q     <= '0;
      perr_q     <= '0;
      for (int i = 0; i < NUM_CH; i++) cnt_q[i] <= '0;
      done_vld   <= 1'b0;
      done_chan  <= '0;
      done_len   <= '0;
      done_err   <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      done_vld  <= 1'b0;
      err_pulse <= cyc_err;
      if (take) begin
        in_burst_q <= ~in_eob;
        if (in_sob) burst_ch_q <= in_chan;
        if (is_eop) begin
          open_q[cyc_ch] <= 1'b0;
          perr_q[cyc_ch] <= 1'b0;
          cnt_q[cyc_ch]  <= '0;
          done_vld       <= 1'b1;
          done_chan      <= cyc_ch;
          done_len       <= total;
          done_err       <= sticky;
        end else begin
          open_q[cyc_ch] <= 1'b1;
          perr_q[cyc_ch] <= sticky;
          cnt_q[cyc_ch]  <= total;
        end
      end
    end
  end

endmodule

module burst_reasm_chk #(
  parameter int CH_W = 4,
  parameter int NV_W = 3,
  parameter int EOP_W = 4,
  parameter int WORDS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_sop,
  input logic             in_sob,
  input logic             in_nvalid_zero_unused,
  input logic [NV_W-1:0]  in_nvalid,
  input logic [EOP_W-1:0] in_eop,
  input logic [CH_W-1:0]  in_chan,
  input logic             in_burst,
  input logic             done_vld,
  input logic [CH_W-1:0]  done_chan,
  input logic             err_pulse
);
  logic armed;
  always_ff @(posedge clk) armed <= rst ? 1'b0 : 1'b1;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && in_nvalid == '0) |=> (!done_vld && !err_pulse));

  // R9
  nv_range_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && in_nvalid > NV_W'(WORDS)) |=> err_pulse);

  // R10
  unframed_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && in_nvalid != '0 && !in_sob && !in_burst) |=> (err_pulse && !done_vld));

  // R2
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && in_nvalid != '0 && in_sob && in_sop && in_eop[EOP_W-1])
      |=> (done_vld && done_chan == $past(in_chan)));

  // R6
  done_short_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && done_vld && !(in_nvalid != '0 && in_eop[EOP_W-1] && (in_sob || in_burst)))
      |=> !done_vld);

  always_comb if (in_nvalid_zero_unused) begin end
endmodule

bind burst_reasm burst_reasm_chk #(.CH_W(CH_W), .NV_W(NV_W), .EOP_W(EOP_W), .WORDS(WORDS)) chk (
  .clk(clk), .rst(rst), .in_sop(in_sop), .in_sob(in_sob),
  .in_nvalid_zero_unused(1'b0), .in_nvalid(in_nvalid), .in_eop(in_eop),
  .in_chan(in_chan), .in_burst(in_burst_q), .done_vld(done_vld),
  .done_chan(done_chan), .err_pulse(err_pulse)
);

// File: tb/burst_reasm_test.sv
module burst_reasm_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic in_sop = 0, in_sob = 0, in_eob = 0;
  logic [2:0] in_nvalid = 0;
  logic [3:0] in_eop = 0, in_chan = 0;
  logic done_vld, done_err, err_pulse;
  logic [3:0] done_chan;
  logic [15:0] done_len;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_reasm uut (.clk(clk), .rst(rst), .in_sop(in_sop), .in_sob(in_sob), .in_eob(in_eob),
    .in_nvalid(in_nvalid), .in_eop(in_eop), .in_chan(in_chan), .done_vld(done_vld),
    .done_chan(done_chan), .done_len(done_len), .done_err(done_err), .err_pulse(err_pulse));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic sop, logic sob, logic eob, int nv, int eop, int ch);
    in_sop = sop; in_sob = sob; in_eob = eob;
    in_nvalid = 3'(nv); in_eop = 4'(eop); in_chan = 4'(ch);
    @(negedge clk);
  endtask

  task automatic none(string req, int perr);
    chk(req, "done_vld", int'(done_vld), 0);
    chk(req, "err_pulse", int'(err_pulse), perr);
  endtask

  task automatic done(string req, int ch, int len, int err, int perr);
    chk(req, "done_vld", int'(done_vld), 1);
    chk(req, "done_chan", int'(done_chan), ch);
    chk(req, "done_len", int'(done_len), len);
    chk(req, "done_err", int'(done_err), err);
    chk(req, "err_pulse", int'(err_pulse), perr);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    none("R12", 0);
    rst = 0;

    // R2 R4 R6 sweep of single-cycle packets
    for (int ch = 0; ch < 16; ch++)
      for (int nv = 1; nv <= 4; nv++)
        for (int t = 0; t < 8; t++) begin
          cyc(1, 1, 1, nv, 8 + t, ch);
          done("R4", ch, (nv - 1) * 8 + (t == 0 ? 8 : t), 0, 0);
        end

    // R3 R5 interleaved packets, channel input changes mid-burst
    cyc(1, 1, 0, 4, 0, 6);   none("R5", 0);
    cyc(0, 0, 1, 4, 0, 9);   none("R3", 0);
    cyc(1, 1, 1, 3, 11, 9);  done("R5", 9, 19, 0, 0);
    // R1 idle cycle with junk strobes
    cyc(1, 1, 1, 0, 8, 6);   none("R1", 0);
    cyc(0, 1, 1, 2, 13, 6);  done("R5", 6, 77, 0, 0);
    // R3 three-cycle burst with changing channel input
    cyc(1, 1, 0, 4, 0, 1);   none("R3", 0);
    cyc(0, 0, 0, 4, 0, 2);   none("R3", 0);
    cyc(0, 0, 1, 1, 12, 3);  done("R3", 1, 68, 0, 0);

    // R9 over-range word count
    cyc(1, 1, 1, 5, 10, 2);  done("R9", 2, 26, 1, 1);
    // R8 continuation on closed channel
    cyc(0, 1, 1, 2, 8, 7);   done("R8", 7, 16, 1, 1);
    // R7 duplicate start
    cyc(1, 1, 1, 4, 0, 11);  none("R7", 0);
    cyc(1, 1, 1, 1, 10, 11); done("R7", 11, 2, 1, 1);
    // R10 R11 unframed data, then channel 5 must be untouched
    cyc(0, 0, 0, 2, 9, 5);   none("R10", 1);
    cyc(1, 1, 1, 1, 9, 5);   done("R11", 5, 1, 0, 0);

    // R12 reset clears an open packet
    cyc(1, 1, 1, 4, 0, 3);   none("R12", 0);
    rst = 1;
    cyc(0, 0, 0, 0, 0, 0);   none("R12", 0);
    rst = 0;
    cyc(0, 1, 1, 1, 12, 3);  done("R12", 3, 4, 1, 1);
    cyc(0, 0, 0, 0, 0, 0);   none("R6", 0);

    finish_up();
  end
endmodule